// File: doc/BRIEF.md
# Content-Directed Pointer Prefetcher

This block sits beside a cache fill path and looks for pointers in each line as it arrives. The fill port carries the line's address and the line itself, a row of 32-bit words. Each word is treated as a candidate address. A word is called a pointer when its high bits match the high bits of the line's own address. The reasoning is that heap data tends to point into the same region of memory as the data that holds the pointer.

Each pointer found becomes a prefetch request for the cache block it targets. The block keeps no table of earlier misses, so it can issue prefetches for addresses nobody has touched yet. Requests leave one at a time through a valid/ready port. While a line still has requests waiting, the fill port is closed.

Top module: `cd_prefetch`

## Requirements
- R1: After reset, `pf_valid` is low and `fill_ready` is high.
- R2: A word of an accepted line becomes a request only when its bits [31:20] equal bits [31:20] of `fill_addr`. Every such word qualifies, whatever its value otherwise.
- R3: `pf_addr` is the qualifying word with its block-offset bits cleared. With the default 8-word (32-byte) line, bits [4:0] are zero.
- R4: Requests leave in ascending word-index order (word 0 is `fill_data[31:0]`), not in address order. While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds its value.
- R5: When several qualifying words of one line fall in the same cache block, a single request is issued for that block, at the position of the lowest-indexed such word.
- R6: While any request of the current line is outstanding, `fill_ready` is low. A `fill_valid` in that time is ignored, and only the held line's requests appear.
- R7: A line with no qualifying word produces no request, and `fill_ready` stays high.
- R8: No state carries over between lines. A line repeated later yields the same requests again.
- R9: With `pf_ready` held high, the requests of a line are issued on consecutive cycles, the first in the cycle after the fill is accepted. `fill_ready` rises in the cycle after the last request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A filled line is offered |
| fill_ready | output | 1 | The block can take a line |
| fill_addr | input | 32 | Address of the filled line |
| fill_data | input | WORDS*32 | Line contents, word 0 in the low bits |
| pf_valid | output | 1 | A prefetch request is present |
| pf_ready | input | 1 | The consumer takes the request |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
The bench offers a word whose top 12 bits differ from the line's by one. A design that compared too few bits would prefetch that word. It also offers lines whose pointers lie in descending address order, to expose a design that sorts by value instead of by index. Lines with two words in one block would reveal a missing or misplaced duplicate filter through an extra request. A second line offered while the first is stalled would, on a design that let it through, replace or mix in addresses. Repeating an earlier line checks that no hidden history suppresses the requests the second time.

// File: rtl/cd_prefetch.sv
module cd_prefetch #(
  parameter int WORDS     = 8,
  parameter int MATCH_LSB = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  output logic                fill_ready,
  input  logic [31:0]         fill_addr,
  input  logic [WORDS*32-1:0] fill_data,
  output logic                pf_valid,
  input  logic                pf_ready,
  output logic [31:0]         pf_addr
);
  localparam int LINE_BYTES = WORDS * 4;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int TAG_W      = 32 - MATCH_LSB;

  logic [WORDS*32-1:0] line_q;
  logic [TAG_W-1:0]    tag_q;
  logic [WORDS-1:0]    pend_q;
  logic [WORDS-1:0]    hit, keep;
  logic [IDX_W-1:0]    sel;
  logic [31:0]         sel_word;
  logic                fill_fire, pf_fire;

  wire addr_unused = &{1'b0, fill_addr[MATCH_LSB-1:0], sel_word[OFF_W-1:0]};

  assign fill_ready = ~|pend_q;
  assign pf_valid   = |pend_q;
  assign fill_fire  = fill_valid & fill_ready;
  assign pf_fire    = pf_valid & pf_ready;

  for (genvar i = 0; i < WORDS; i++) begin : g_hit
    assign hit[i] = fill_data[i*32+MATCH_LSB +: TAG_W] == fill_addr[31:MATCH_LSB];
  end

  always_comb begin
    keep = hit;
    for (int i = 1; i < WORDS; i++)
      for (int j = 0; j < i; j++)
        if (hit[j] && fill_data[j*32+OFF_W +: 32-OFF_W] == fill_data[i*32+OFF_W +: 32-OFF_W])
          keep[i] = 1'b0;
  end

  always_comb begin
    sel = '0;
    for (int i = WORDS - 1; i >= 0; i--)
      if (pend_q[i]) sel = IDX_W'(i);
  end

  assign sel_word = line_q[sel*32 +: 32];
  assign pf_addr  = {sel_word[31:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      tag_q  <= '0;
      line_q <= '0;
    end else if (fill_fire) begin
      pend_q <= keep;
      tag_q  <= fill_addr[31:MATCH_LSB];
      line_q <= fill_data;
    end else if (pf_fire) begin
      pend_q[sel] <= 1'b0;
    end
  end

  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[OFF_W-1:0] == '0);

  p_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[31:MATCH_LSB] == tag_q);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  p_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fire |=> !(pf_valid && pf_addr == $past(pf_addr)));

  p_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_fire |=> $stable(tag_q));

  p_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fire && $countones(pend_q) == 1 |=> fill_ready);
endmodule

// File: tb/test_cd_prefetch.sv
module test_cd_prefetch;
  localparam int WORDS = 8;

  logic                clk = 0;
  logic                rst_n = 0;
  logic                fill_valid = 0;
  logic                fill_ready;
  logic [31:0]         fill_addr = 0;
  logic [WORDS*32-1:0] fill_data = 0;
  logic                pf_valid;
  logic                pf_ready = 0;
  logic [31:0]         pf_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cd_prefetch #(.WORDS(WORDS)) i_cd_prefetch (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_data(fill_data), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] blk(logic [31:0] w);
    return w & ~32'h1F;
  endfunction

  task automatic offer(logic [31:0] a, logic [31:0] w [WORDS]);
    @(negedge clk);
    fill_addr  = a;
    for (int i = 0; i < WORDS; i++) fill_data[i*32 +: 32] = w[i];
    fill_valid = 1;
    @(posedge clk);
    #1 fill_valid = 0;
    @(negedge clk);
  endtask

  task automatic drain(string req, int n, logic [31:0] e [WORDS]);
    pf_ready = 1;
    for (int k = 0; k < n; k++) begin
      check({req, " valid"}, 32'(pf_valid), 32'd1);
      check({req, " addr"}, pf_addr, e[k]);
      check({req, " fill closed R6"}, 32'(fill_ready), 32'(k == n));
      @(negedge clk);
    end
    check({req, " done R9"}, 32'(pf_valid), 32'd0);
    check({req, " reopen R9"}, 32'(fill_ready), 32'd1);
  endtask

  task automatic t_reset;
    check("R1 pf_valid", 32'(pf_valid), 32'd0);
    check("R1 fill_ready", 32'(fill_ready), 32'd1);
  endtask

  task automatic t_basic;
    logic [31:0] w [WORDS];
    logic [31:0] e [WORDS];
    w = '{32'h1234_5678, 32'h4560_0000, 32'h123F_FFFF, 32'h1220_0000,
          32'h1230_0004, 32'h0, 32'h1240_0000, 32'h0};
    e = '{blk(32'h1234_5678), blk(32'h123F_FFFF), blk(32'h1230_0004), 0, 0, 0, 0, 0};
    pf_ready = 1;
    offer(32'h1230_0040, w);
    drain("R2 R3 basic", 3, e);
  endtask

  task automatic t_order;
    logic [31:0] w [WORDS];
    logic [31:0] e [WORDS];
    for (int i = 0; i < WORDS; i++) begin
      w[i] = 32'h7FF0_0000 + 32'((WORDS - i) * 32'h100) + 32'(i);
      e[i] = blk(w[i]);
    end
    pf_ready = 1;
    offer(32'h7FF8_0000, w);
    drain("R4 index order", WORDS, e);
  endtask

  task automatic t_stall;
    logic [31:0] w [WORDS];
    logic [31:0] w2 [WORDS];
    logic [31:0] e [WORDS];
    w  = '{32'h0, 32'h5550_1234, 32'h0, 32'h0, 32'h5551_0000, 32'h0, 32'h0, 32'h0};
    w2 = '{32'h5550_8888, 32'h5550_9999, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    e  = '{blk(32'h5550_1234), 32'h5551_0000, 0, 0, 0, 0, 0, 0};
    pf_ready = 0;
    offer(32'h5550_0000, w);
    fill_addr  = 32'h5550_0000;
    for (int i = 0; i < WORDS; i++) fill_data[i*32 +: 32] = w2[i];
    fill_valid = 1;
    for (int k = 0; k < 4; k++) begin
      check("R4 hold valid", 32'(pf_valid), 32'd1);
      check("R4 hold addr", pf_addr, e[0]);
      check("R6 fill_ready low", 32'(fill_ready), 32'd0);
      @(negedge clk);
    end
    fill_valid = 0;
    drain("R6 ignored fill", 2, e);
  endtask

  task automatic t_dedup;
    logic [31:0] w [WORDS];
    logic [31:0] e [WORDS];
    w = '{32'h2000_1004, 32'h2000_1010, 32'h2000_1020, 32'h2000_101C,
          32'h0, 32'h2000_1024, 32'h0, 32'h0};
    e = '{32'h2000_1000, 32'h2000_1020, 0, 0, 0, 0, 0, 0};
    pf_ready = 1;
    offer(32'h2000_0000, w);
    drain("R5 dedup", 2, e);
  endtask

  task automatic t_nomatch;
    logic [31:0] w [WORDS];
    for (int i = 0; i < WORDS; i++) w[i] = 32'h9910_0000 + 32'(i * 64);
    pf_ready = 1;
    offer(32'h9900_0000, w);
    for (int k = 0; k < 3; k++) begin
      check("R7 no request", 32'(pf_valid), 32'd0);
      check("R7 fill_ready", 32'(fill_ready), 32'd1);
      @(negedge clk);
    end
  endtask

  task automatic t_repeat;
    logic [31:0] w [WORDS];
    logic [31:0] e [WORDS];
    w = '{32'h0, 32'h0, 32'h3333_0100, 32'h0, 32'h0, 32'h0, 32'h3333_0200, 32'h0};
    e = '{32'h3333_0100, 32'h3333_0200, 0, 0, 0, 0, 0, 0};
    pf_ready = 1;
    offer(32'h3330_0000, w);
    drain("R8 first", 2, e);
    offer(32'h3330_0000, w);
    drain("R8 repeat", 2, e);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_order;
    t_stall;
    t_dedup;
    t_nomatch;
    t_repeat;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule